// File: doc/BRIEF.md
# Serial Systematic BCH(15,5) Encoder

This block turns a 5-bit message into a 15-bit codeword of the binary BCH code that corrects up to three bit errors. The field underneath the code is GF(16), built on the primitive polynomial x^4+x+1. The codeword is systematic. The five message bits leave the block first and unchanged. They are followed by ten check bits, which are the remainder of x^10·i(x) divided by the generator g(x) = x^10+x^8+x^5+x^4+x^2+x+1.

The message is captured in parallel when the block is idle and a start pulse arrives. A load register then feeds it, one bit per cycle and highest coefficient first, into a ten-stage division register. For the first five cycles the division register runs with feedback and the output selector passes the message bit. For the last ten cycles the feedback is gated off and the register drains its contents as the parity bits. While the bits leave on the serial port, a collector gathers them. After the fifteenth bit the collector publishes the whole word on a parallel port together with a one-cycle done pulse.

Top module: `bch_ser_enc`

## Requirements
- R1: While reset is held and right after it, ready is 1, code_vld is 0, done is 0 and code_word is all zeros.
- R2: A start that is sampled high while ready is 1 makes code_vld go high on the next cycle. code_vld then stays high for exactly 15 consecutive cycles, and ready stays low for that whole time.
- R3: The first 5 valid serial bits are msg_in as it was captured, bit 4 first and bit 0 last.
- R4: Valid bits 6 to 15 are the coefficients of x^9 down to x^0 of the remainder of x^10·i(x) modulo g(x). Here g(x) = x^10+x^8+x^5+x^4+x^2+x+1, which is 11'h537 with bit j standing for x^j.
- R5: Every codeword, read as a polynomial with code_word bit j as the coefficient of x^j, is divisible by g(x). This holds for all 32 messages.
- R6: done is high for exactly one cycle, namely the cycle right after the 15th valid bit. In that same cycle ready is back at 1 and code_vld is 0.
- R7: code_word takes a new value only in the done cycle. Its bit 14 is the first serial bit and its bit 0 is the last. It holds that value until the next done.
- R8: start and msg_in are ignored while an encode is running. The serial bits and the final word depend only on the message captured at the accepted start.
- R9: The division register clears on every accepted start. A start accepted in the done cycle, back to back with the previous encode, produces a codeword that does not depend on the earlier message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to capture msg_in and begin an encode |
| msg_in | input | 5 | Message word, bit 4 is the highest coefficient |
| ready | output | 1 | Block is idle and will accept start |
| code_bit | output | 1 | Serial codeword bit, highest coefficient first |
| code_vld | output | 1 | code_bit carries a codeword bit |
| code_word | output | 15 | Last completed codeword, bit 14 sent first |
| done | output | 1 | One-cycle pulse when code_word updates |

## Verification
The cycle of the start edge is counted as cycle 0. Serial bit m (m = 0 to 14) appears on code_bit during cycle m+1. done, the new code_word and the return of ready all appear together in cycle 16. The bench runs its reference model on the rising edge, using the same inputs the design samples at that edge. It compares every output at the following falling edge, so each expected value is checked in exactly the cycle it is due. Back-to-back encodes, extra start pulses during a run, and message changes during a run are all placed at known cycles, so their lack of effect shows up in those same per-cycle comparisons.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

   // generator of the (15,5) triple-error-correcting code, bit j = coefficient of x^j
   localparam logic [10:0] BCH15_5_GEN = 11'h537;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_MSG  = 2'd1,
      PH_PAR  = 2'd2
   } enc_phase_e;

endpackage

// File: rtl/bch_msg_piso.sv
module bch_msg_piso #(
   parameter int K = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [K-1:0] data_in,
   output logic         bit_out
);
   logic [K-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= data_in;
      end else if (shift) begin
         sr_q <= {sr_q[K-2:0], 1'b0};
      end
   end

   assign bit_out = sr_q[K-1];
endmodule

// File: rtl/bch_div_lfsr.sv
module bch_div_lfsr #(
   parameter int              P   = 10,
   parameter logic [P:0]      GEN = 11'h537
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic shift,
   input  logic fb_en,
   input  logic din,
   output logic top_bit
);
   logic [P-1:0] rem_q;
   logic [P-1:0] rem_d;
   logic         fb;

   assign fb = fb_en & (din ^ rem_q[P-1]);

   genvar j;
   generate
      for (j = 0; j < P; j++) begin : g_stage
         if (j == 0) begin : g_first
            if (GEN[0]) begin : g_tap
               assign rem_d[0] = fb;
            end else begin : g_notap
               assign rem_d[0] = 1'b0;
            end
         end else begin : g_rest
            if (GEN[j]) begin : g_tap
               assign rem_d[j] = rem_q[j-1] ^ fb;
            end else begin : g_notap
               assign rem_d[j] = rem_q[j-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         rem_q <= '0;
      end else if (shift) begin
         rem_q <= rem_d;
      end
   end

   assign top_bit = rem_q[P-1];
endmodule

// File: rtl/bch_cw_sipo.sv
module bch_cw_sipo #(
   parameter int N = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         last,
   input  logic         bit_in,
   output logic [N-1:0] word_out
);
   logic [N-2:0] acc_q;
   logic [N-1:0] word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         word_q <= '0;
      end else if (shift) begin
         acc_q <= {acc_q[N-3:0], bit_in};
         if (last) begin
            word_q <= {acc_q, bit_in};
         end
      end
   end

   assign word_out = word_q;
endmodule

// File: rtl/bch_enc_seq.sv
module bch_enc_seq
   import bch_enc_pkg::*;
#(
   parameter int N = 15,
   parameter int K = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic shift,
   output logic msg_phase,
   output logic last,
   output logic ready,
   output logic done
);
   localparam int CW = $clog2(N + 1);

   enc_phase_e     phase_q;
   logic [CW-1:0]  cnt_q;
   logic           done_q;

   assign ready     = (phase_q == PH_IDLE);
   assign load      = ready & start;
   assign shift     = (phase_q != PH_IDLE);
   assign msg_phase = (phase_q == PH_MSG);
   assign last      = shift && (cnt_q == CW'(N - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (load) begin
            phase_q <= PH_MSG;
            cnt_q   <= '0;
         end else if (shift) begin
            cnt_q <= cnt_q + 1'b1;
            if (last) begin
               phase_q <= PH_IDLE;
            end else if (cnt_q == CW'(K - 1)) begin
               phase_q <= PH_PAR;
            end
         end
      end
   end

   assign done = done_q;
endmodule

// File: rtl/bch_ser_enc.sv
module bch_ser_enc #(
   parameter int               N   = 15,
   parameter int               K   = 5,
   parameter logic [N-K:0]     GEN = bch_enc_pkg::BCH15_5_GEN
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [K-1:0] msg_in,
   output logic         ready,
   output logic         code_bit,
   output logic         code_vld,
   output logic [N-1:0] code_word,
   output logic         done
);
   localparam int P = N - K;

   generate
      if (K < 2 || P < 2) begin : g_bad_len
         $error("bch_ser_enc: need K >= 2 and N-K >= 2");
      end
      if (!GEN[P] || !GEN[0]) begin : g_bad_gen
         $error("bch_ser_enc: generator must have degree N-K and a constant term");
      end
   endgenerate

   logic load, shift, msg_phase, last;
   logic msg_bit, par_bit;

   bch_enc_seq #(.N(N), .K(K)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .load      (load),
      .shift     (shift),
      .msg_phase (msg_phase),
      .last      (last),
      .ready     (ready),
      .done      (done)
   );

   bch_msg_piso #(.K(K)) u_piso (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .shift   (shift),
      .data_in (msg_in),
      .bit_out (msg_bit)
   );

   bch_div_lfsr #(.P(P), .GEN(GEN)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (load),
      .shift   (shift),
      .fb_en   (msg_phase),
      .din     (msg_bit),
      .top_bit (par_bit)
   );

   // output selector: message bit during the first K cycles, remainder after
   assign code_bit = msg_phase ? msg_bit : par_bit;
   assign code_vld = shift;

   bch_cw_sipo #(.N(N)) u_sipo (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift    (shift),
      .last     (last),
      .bit_in   (code_bit),
      .word_out (code_word)
   );
endmodule

// File: rtl/bch_ser_enc_chk.sv
module bch_ser_enc_chk #(
   parameter int N = 15
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         ready,
   input logic         code_vld,
   input logic [N-1:0] code_word,
   input logic         done
);
   localparam int LW = $clog2(N + 2);

   logic [LW-1:0] run_len;
   logic          vld_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
         vld_d   <= 1'b0;
      end else begin
         vld_d <= code_vld;
         if (code_vld) begin
            run_len <= vld_d ? run_len + 1'b1 : LW'(1);
         end
      end
   end

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> (code_vld && !ready));

   // R2
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld |-> !ready);

   // R2
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_len == LW'(N)));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(code_vld) |-> (done && ready));

   // R7
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(code_word));
endmodule

bind bch_ser_enc bch_ser_enc_chk #(.N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .ready     (ready),
   .code_vld  (code_vld),
   .code_word (code_word),
   .done      (done)
);

// File: tb/tb_bch_ser_enc.sv
`timescale 1ns/1ps
module tb_bch_ser_enc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  msg_in = '0;
   logic        ready, code_bit, code_vld, done;
   logic [14:0] code_word;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   bch_ser_enc dut (
      .clk(clk), .rst_n(rst_n), .start(start), .msg_in(msg_in),
      .ready(ready), .code_bit(code_bit), .code_vld(code_vld),
      .code_word(code_word), .done(done)
   );

   localparam int G = 'h537;

   function automatic int enc_ref(input int m);
      int r = (m & 31) << 10;
      for (int i = 14; i >= 10; i--)
         if ((r >> i) & 1) r = r ^ (G << (i - 10));
      return ((m & 31) << 10) | (r & 'h3FF);
   endfunction

   function automatic int mod_g(input int w);
      int r = w;
      for (int i = 14; i >= 10; i--)
         if ((r >> i) & 1) r = r ^ (G << (i - 10));
      return r;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference: position in the codeword, -1 when idle
   int m_pos = -1;
   int m_cur = 0;
   int m_word = 0;
   int m_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = -1; m_word = 0; m_done = 0;
      end else if (m_pos < 0) begin
         m_done = 0;
         if (start) begin m_cur = enc_ref(int'(msg_in)); m_pos = 0; end
      end else if (m_pos == 14) begin
         m_pos = -1; m_done = 1; m_word = m_cur;
      end else begin
         m_pos++; m_done = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 ready", int'(ready), int'(m_pos < 0));
         chk("R2 code_vld", int'(code_vld), int'(m_pos >= 0));
         if (m_pos >= 0)
            chk(m_pos < 5 ? "R3 message bit" : "R4 parity bit",
                int'(code_bit), (m_cur >> (14 - m_pos)) & 1);
         chk("R6 done", int'(done), m_done);
         chk("R7 code_word", int'(code_word), m_word);
         if (done) chk("R5 divisible by g", mod_g(int'(code_word)), 0);
      end
   end

   task automatic encode_one(input int m, input bit poke);
      while (!ready) @(negedge clk);
      start = 1'b1; msg_in = 5'(m);
      @(negedge clk);
      start = 1'b0; msg_in = 5'(~m);   // R8: message change mid-run
      if (poke) begin
         repeat (3) @(negedge clk);
         start = 1'b1; msg_in = 5'(m ^ 5'h15);  // R8: start while busy
         @(negedge clk);
         start = 1'b0;
      end
      do @(negedge clk); while (!done);
      chk(poke ? "R8 word after busy start" : "R9 word back to back",
          int'(code_word), enc_ref(m));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ready", int'(ready), 1);
      chk("R1 code_vld", int'(code_vld), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 code_word", int'(code_word), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", int'(code_vld), 0);
      for (int m = 0; m < 32; m++) encode_one(m, m[0]);
      // R9: all-ones then zero back to back must yield an all-zero word
      encode_one(31, 1'b0);
      encode_one(0, 1'b0);
      chk("R9 zero after ones", int'(code_word), 0);
      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule